// File: doc/BRIEF.md
# Peer-to-Peer Request Forwarding Decoder

This block sits behind the PCI target decode logic of a bridge. For each incoming PCI request it decides whether to forward the request to the HyperTransport fabric, route it to the internal system bus, or leave it unclaimed. Its inputs are the request's attributes: the I/O or memory space flag, the address, the BAR0 hit flag, and the enable and send-to-HT flags of the BAR0 map entry. It compares the address against a secondary-bus memory window. The window's base and limit arrive on input ports and are held in registers inside the block.

Two paths lead to the fabric. The first is the secondary-bus window. It works only when the bridge runs as a host, and only after software has enabled window forwarding. The second is a BAR0 mapping marked send-to-HT. That mapping overrides the destination the address would otherwise imply. It also needs a separate peer-to-peer enable bit. In device mode the PCI host alone owns this feature-control register, because writes from the internal system bus are dropped. A non-transparent route to the fabric therefore opens only when both sides agree: the local map entry must be set, and the PCI host must have set the enable bit.

Top module: `p2p_fwd_decoder`

## Requirements
- R1: A request with `reqIsIo` high is always answered with `noClaim`, whatever the other attributes and the feature bits are.
- R2: After reset both feature bits are clear and all decision outputs are low. A host-mode memory request inside the window therefore gets `noClaim` until window forwarding is enabled.
- R3: In host mode (`deviceMode` = 0), a memory request with no BAR0 hit and an address satisfying base <= address <= limit (both bounds inclusive) is forwarded to HT when feature bit 0 (window forward enable) is set. An address outside the window gets `noClaim`.
- R4: A memory request with `bar0Hit`, `mapEnable` and `mapSendHt` all high is forwarded to HT when feature bit 1 (peer-to-peer enable) is set, even if its address lies outside the window. With bit 1 clear it gets `noClaim`.
- R5: In device mode (`deviceMode` = 1) the window path is ignored. A non-BAR0 request inside the window gets `noClaim` even with bit 0 set.
- R6: A feature write with `cfgWrFromSys` = 1 (internal system-bus source) is dropped while `deviceMode` = 1 and takes effect while `deviceMode` = 0. A write with `cfgWrFromSys` = 0 (PCI configuration source) always takes effect.
- R7: Only a write with `cfgWrOffset` = 0x40 updates the feature register. A write to any other offset leaves it unchanged.
- R8: A memory request with `bar0Hit` high and `mapSendHt` low is routed to the internal bus (`fwdInternal`), whatever `mapEnable` is. A BAR0 hit with `mapSendHt` high but `mapEnable` low gets `noClaim`.
- R9: The decision appears one clock after the `reqValid` strobe. `decValid` is high for that one cycle, with exactly one of `fwdHt`, `fwdInternal` and `noClaim` high. In every other cycle all four outputs are low.
- R10: A request that arrives in the same cycle as a feature write is decided with the register value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| deviceMode | input | 1 | 1 = device mode, 0 = host mode |
| cfgWrEn | input | 1 | Feature-register write strobe |
| cfgWrFromSys | input | 1 | Write source: 1 = internal system bus, 0 = PCI configuration |
| cfgWrOffset | input | 8 | Configuration offset of the write |
| cfgWrData | input | 8 | Write data; bit 0 = window forward enable, bit 1 = peer-to-peer enable |
| winBase | input | ADDR_W | Secondary-bus window base, held in a register |
| winLimit | input | ADDR_W | Secondary-bus window limit (inclusive), held in a register |
| reqValid | input | 1 | Request strobe |
| reqIsIo | input | 1 | 1 = I/O space request |
| reqAddr | input | ADDR_W | Request address |
| bar0Hit | input | 1 | Request hits BAR0 |
| mapEnable | input | 1 | BAR0 map entry enabled |
| mapSendHt | input | 1 | BAR0 map entry marked send-to-HT |
| decValid | output | 1 | Decision valid |
| fwdHt | output | 1 | Forward to the HT fabric |
| fwdInternal | output | 1 | Route to the internal system bus |
| noClaim | output | 1 | Request not claimed |

## Verification
Two functions can fall in the same cycle: a feature-register write and a request decision. The bench raises `cfgWrEn` and `reqValid` on the same clock edge. It does this once to set an enable bit and once to clear it. The decision for that request must follow the old register value. A second request issued right afterwards must follow the new value. The same collision is checked again with a system-bus write in device mode, where the write must be dropped, so the decisions before and after stay the same.

// File: rtl/p2p_fwd_pkg.sv
package p2p_fwd_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic featWr;      // accepted write to the feature register
    logic reqCapture;  // register a decision this cycle
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    DEC_NOCLAIM  = 2'd0,
    DEC_HT       = 2'd1,
    DEC_INTERNAL = 2'd2
  } decision_e;

endpackage

// File: rtl/p2p_fwd_ctrl.sv
module p2p_fwd_ctrl
  import p2p_fwd_pkg::*;
#(
  parameter int OFF_W = 8,
  parameter logic [OFF_W-1:0] FEAT_OFFSET = 8'h40
) (
  input  logic             cfgWrEn,
  input  logic             cfgWrFromSys,
  input  logic [OFF_W-1:0] cfgWrOffset,
  input  logic             deviceMode,
  input  logic             reqValid,
  output ctrlStrobes_t     strobes
);

  logic offsetMatch;
  logic sourceAllowed;

  always_comb begin
    offsetMatch   = (cfgWrOffset == FEAT_OFFSET);
    // in device mode only the PCI host may program the register
    sourceAllowed = !(cfgWrFromSys && deviceMode);
    strobes.featWr     = cfgWrEn && offsetMatch && sourceAllowed;
    strobes.reqCapture = reqValid;
  end

endmodule

// File: rtl/p2p_fwd_datapath.sv
module p2p_fwd_datapath
  import p2p_fwd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 8,
  parameter int WIN_EN_BIT = 0,
  parameter int P2P_EN_BIT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic              deviceMode,
  input  logic [ADDR_W-1:0] winBase,
  input  logic [ADDR_W-1:0] winLimit,
  input  logic              reqIsIo,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              bar0Hit,
  input  logic              mapEnable,
  input  logic              mapSendHt,
  output logic              decValid,
  output logic              fwdHt,
  output logic              fwdInternal,
  output logic              noClaim,
  output logic              featWinEn,
  output logic              featP2pEn
);

  logic [ADDR_W-1:0] baseQ;
  logic [ADDR_W-1:0] limitQ;
  logic              winHit;
  decision_e         decNext;

  // feature register: only the two enable bits are stored
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      featWinEn <= 1'b0;
      featP2pEn <= 1'b0;
    end else if (strobes.featWr) begin
      featWinEn <= cfgWrData[WIN_EN_BIT];
      featP2pEn <= cfgWrData[P2P_EN_BIT];
    end
  end

  // window bounds held in registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ  <= '0;
      limitQ <= '0;
    end else begin
      baseQ  <= winBase;
      limitQ <= winLimit;
    end
  end

  always_comb begin
    winHit = (reqAddr >= baseQ) && (reqAddr <= limitQ);
  end

  always_comb begin
    decNext = DEC_NOCLAIM;
    if (reqIsIo) begin
      decNext = DEC_NOCLAIM;
    end else if (bar0Hit) begin
      if (!mapSendHt)
        decNext = DEC_INTERNAL;
      else if (mapEnable && featP2pEn)
        decNext = DEC_HT;
      else
        decNext = DEC_NOCLAIM;
    end else if (!deviceMode && winHit && featWinEn) begin
      decNext = DEC_HT;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decValid    <= 1'b0;
      fwdHt       <= 1'b0;
      fwdInternal <= 1'b0;
      noClaim     <= 1'b0;
    end else begin
      decValid    <= strobes.reqCapture;
      fwdHt       <= strobes.reqCapture && (decNext == DEC_HT);
      fwdInternal <= strobes.reqCapture && (decNext == DEC_INTERNAL);
      noClaim     <= strobes.reqCapture && (decNext == DEC_NOCLAIM);
    end
  end

endmodule

// File: rtl/p2p_fwd_decoder.sv
module p2p_fwd_decoder
  import p2p_fwd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 8,
  parameter int DATA_W = 8,
  parameter logic [OFF_W-1:0] FEAT_OFFSET = 8'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              deviceMode,
  input  logic              cfgWrEn,
  input  logic              cfgWrFromSys,
  input  logic [OFF_W-1:0]  cfgWrOffset,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic [ADDR_W-1:0] winBase,
  input  logic [ADDR_W-1:0] winLimit,
  input  logic              reqValid,
  input  logic              reqIsIo,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              bar0Hit,
  input  logic              mapEnable,
  input  logic              mapSendHt,
  output logic              decValid,
  output logic              fwdHt,
  output logic              fwdInternal,
  output logic              noClaim
);

  ctrlStrobes_t strobes;
  logic         featWinEn;
  logic         featP2pEn;

  p2p_fwd_ctrl #(
    .OFF_W(OFF_W), .FEAT_OFFSET(FEAT_OFFSET)
  ) uCtrl (
    .cfgWrEn(cfgWrEn), .cfgWrFromSys(cfgWrFromSys), .cfgWrOffset(cfgWrOffset),
    .deviceMode(deviceMode), .reqValid(reqValid), .strobes(strobes)
  );

  p2p_fwd_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_EN_BIT(0), .P2P_EN_BIT(1)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgWrData(cfgWrData),
    .deviceMode(deviceMode), .winBase(winBase), .winLimit(winLimit),
    .reqIsIo(reqIsIo), .reqAddr(reqAddr), .bar0Hit(bar0Hit),
    .mapEnable(mapEnable), .mapSendHt(mapSendHt),
    .decValid(decValid), .fwdHt(fwdHt), .fwdInternal(fwdInternal),
    .noClaim(noClaim), .featWinEn(featWinEn), .featP2pEn(featP2pEn)
  );

endmodule

// File: rtl/p2p_fwd_checker.sv
module p2p_fwd_checker (
  input logic clk,
  input logic rstN,
  input logic deviceMode,
  input logic cfgWrEn,
  input logic cfgWrFromSys,
  input logic reqValid,
  input logic reqIsIo,
  input logic bar0Hit,
  input logic decValid,
  input logic fwdHt,
  input logic fwdInternal,
  input logic noClaim,
  input logic featWinEn,
  input logic featP2pEn
);

  // R9: one decision per strobe, one clock later
  a_r9_latency: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> decValid);
  a_r9_idle: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !decValid);
  a_r9_onehot: assert property (@(posedge clk) disable iff (!rstN)
    decValid |-> $onehot({fwdHt, fwdInternal, noClaim}));
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |-> !(fwdHt || fwdInternal || noClaim));

  // R1: I/O requests never claimed
  a_r1_io_noclaim: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqIsIo) |=> noClaim);

  // R5: window path ignored in device mode
  a_r5_dev_window: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && deviceMode && !bar0Hit) |=> noClaim);

  // R4: map forwarding needs the peer-to-peer bit
  a_r4_map_needs_p2p: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && bar0Hit && !featP2pEn) |=> !fwdHt);

  // R6: system-bus writes dropped in device mode
  a_r6_sys_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgWrFromSys && deviceMode) |=> $stable({featWinEn, featP2pEn}));

endmodule

bind p2p_fwd_decoder p2p_fwd_checker uChk (
  .clk(clk), .rstN(rstN), .deviceMode(deviceMode), .cfgWrEn(cfgWrEn),
  .cfgWrFromSys(cfgWrFromSys), .reqValid(reqValid), .reqIsIo(reqIsIo),
  .bar0Hit(bar0Hit), .decValid(decValid), .fwdHt(fwdHt),
  .fwdInternal(fwdInternal), .noClaim(noClaim),
  .featWinEn(featWinEn), .featP2pEn(featP2pEn)
);

// File: tb/sim_p2p_fwd_decoder.sv
`timescale 1ns/1ps
module sim_p2p_fwd_decoder;

  localparam int ADDR_W = 32;
  localparam logic [2:0] E_HT  = 3'b100;
  localparam logic [2:0] E_INT = 3'b010;
  localparam logic [2:0] E_NC  = 3'b001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic deviceMode = 1'b0;
  logic cfgWrEn = 1'b0, cfgWrFromSys = 1'b0;
  logic [7:0] cfgWrOffset = '0, cfgWrData = '0;
  logic [ADDR_W-1:0] winBase = 32'h1000_0000, winLimit = 32'h1FFF_FFFF;
  logic reqValid = 1'b0, reqIsIo = 1'b0, bar0Hit = 1'b0, mapEnable = 1'b0, mapSendHt = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic decValid, fwdHt, fwdInternal, noClaim;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  p2p_fwd_decoder u0 (
    .clk(clk), .rstN(rstN), .deviceMode(deviceMode), .cfgWrEn(cfgWrEn),
    .cfgWrFromSys(cfgWrFromSys), .cfgWrOffset(cfgWrOffset), .cfgWrData(cfgWrData),
    .winBase(winBase), .winLimit(winLimit), .reqValid(reqValid), .reqIsIo(reqIsIo),
    .reqAddr(reqAddr), .bar0Hit(bar0Hit), .mapEnable(mapEnable), .mapSendHt(mapSendHt),
    .decValid(decValid), .fwdHt(fwdHt), .fwdInternal(fwdInternal), .noClaim(noClaim)
  );

  task automatic checkDec(input string tag, input logic [2:0] exp);
    checks++;
    if (!decValid || {fwdHt, fwdInternal, noClaim} !== exp) begin
      errors++;
      $display("FAIL %s: valid=%b dec=%b expected valid=1 dec=%b",
               tag, decValid, {fwdHt, fwdInternal, noClaim}, exp);
    end
  endtask

  // set request at a falling edge, judge at the next falling edge
  task automatic setReq(input logic io, input logic [ADDR_W-1:0] a,
                        input logic b0, input logic me, input logic ms);
    reqValid = 1'b1; reqIsIo = io; reqAddr = a;
    bar0Hit = b0; mapEnable = me; mapSendHt = ms;
  endtask

  task automatic doReq(input string tag, input logic io, input logic [ADDR_W-1:0] a,
                       input logic b0, input logic me, input logic ms,
                       input logic [2:0] exp);
    @(negedge clk);
    setReq(io, a, b0, me, ms);
    @(negedge clk);
    reqValid = 1'b0;
    checkDec(tag, exp);
  endtask

  task automatic cfgWrite(input logic fromSys, input logic [7:0] off, input logic [7:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrFromSys = fromSys; cfgWrOffset = off; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic testReset();
    checks++;
    if (decValid !== 1'b0 || {fwdHt, fwdInternal, noClaim} !== 3'b000) begin
      errors++;
      $display("FAIL R2 reset outputs: got %b%b%b%b expected 0000",
               decValid, fwdHt, fwdInternal, noClaim);
    end
    doReq("R2 window hit before enable", 0, 32'h1000_0040, 0, 0, 0, E_NC);
    @(negedge clk);
    checks++;
    if (decValid !== 1'b0 || {fwdHt, fwdInternal, noClaim} !== 3'b000) begin
      errors++;
      $display("FAIL R9 idle after decision: got %b%b%b%b expected 0000",
               decValid, fwdHt, fwdInternal, noClaim);
    end
  endtask

  task automatic testHostWindow();
    deviceMode = 1'b0;
    cfgWrite(0, 8'h40, 8'h01);
    doReq("R3 window base inclusive", 0, 32'h1000_0000, 0, 0, 0, E_HT);
    doReq("R3 window limit inclusive", 0, 32'h1FFF_FFFF, 0, 0, 0, E_HT);
    doReq("R3 below base", 0, 32'h0FFF_FFFF, 0, 0, 0, E_NC);
    doReq("R3 above limit", 0, 32'h2000_0000, 0, 0, 0, E_NC);
    doReq("R1 io in window", 1, 32'h1000_0010, 0, 0, 0, E_NC);
  endtask

  task automatic testBar0();
    doReq("R4 map without p2p", 0, 32'h8000_0000, 1, 1, 1, E_NC);
    cfgWrite(0, 8'h40, 8'h03);
    doReq("R4 map override outside window", 0, 32'h8000_0000, 1, 1, 1, E_HT);
    doReq("R8 bar0 internal", 0, 32'h1000_0000, 1, 1, 0, E_INT);
    doReq("R8 bar0 internal map disabled", 0, 32'h8000_0000, 1, 0, 0, E_INT);
    doReq("R8 sendHt with map disabled", 0, 32'h8000_0000, 1, 0, 1, E_NC);
    doReq("R1 io on bar0 send", 1, 32'h8000_0000, 1, 1, 1, E_NC);
  endtask

  task automatic testOffset();
    cfgWrite(0, 8'h44, 8'h00);
    doReq("R7 other offset ignored", 0, 32'h8000_0000, 1, 1, 1, E_HT);
    cfgWrite(1, 8'h40, 8'h01);  // host mode: system write applies
    doReq("R6 host sys write clears p2p", 0, 32'h8000_0000, 1, 1, 1, E_NC);
    doReq("R6 host sys write keeps window", 0, 32'h1800_0000, 0, 0, 0, E_HT);
  endtask

  task automatic testDevice();
    deviceMode = 1'b1;
    doReq("R5 device window ignored", 0, 32'h1800_0000, 0, 0, 0, E_NC);
    cfgWrite(1, 8'h40, 8'h03);  // dropped
    doReq("R6 device sys write dropped", 0, 32'h8000_0000, 1, 1, 1, E_NC);
    cfgWrite(0, 8'h40, 8'h03);
    doReq("R6 device pci write applies", 0, 32'h8000_0000, 1, 1, 1, E_HT);
    doReq("R5 device window with bit0", 0, 32'h1800_0000, 0, 0, 0, E_NC);
    doReq("R1 io device", 1, 32'h8000_0000, 1, 1, 1, E_NC);
  endtask

  task automatic testCollision();
    // device mode, bits = 11; clear via PCI in same cycle as a request
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrFromSys = 1'b0; cfgWrOffset = 8'h40; cfgWrData = 8'h00;
    setReq(0, 32'h8000_0000, 1, 1, 1);
    @(negedge clk);
    cfgWrEn = 1'b0; reqValid = 1'b0;
    checkDec("R10 clear collides, old value used", E_HT);
    doReq("R10 after clear", 0, 32'h8000_0000, 1, 1, 1, E_NC);
    // system-bus write in device mode collides: dropped
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrFromSys = 1'b1; cfgWrData = 8'h02;
    setReq(0, 32'h8000_0000, 1, 1, 1);
    @(negedge clk);
    cfgWrEn = 1'b0; reqValid = 1'b0;
    checkDec("R10 sys collide device", E_NC);
    doReq("R6 after dropped collide", 0, 32'h8000_0000, 1, 1, 1, E_NC);
    // host mode set collides
    deviceMode = 1'b0;
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrFromSys = 1'b0; cfgWrData = 8'h01;
    setReq(0, 32'h1000_0000, 0, 0, 0);
    @(negedge clk);
    cfgWrEn = 1'b0; reqValid = 1'b0;
    checkDec("R10 set collides, old value used", E_NC);
    doReq("R10 after set", 0, 32'h1000_0000, 0, 0, 0, E_HT);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testHostWindow();
    testBar0();
    testOffset();
    testDevice();
    testCollision();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule